// File: doc/BRIEF.md
# Display Control Register Decoder

The block sits behind the control port of a graphics processor. Every 32-bit word written there carries a command number in its top byte and an argument in the remaining bits. The decoder keeps a status word and a set of display geometry registers: the display start position, the horizontal scan range and the vertical scan range. It updates each of them from the fields of the command that targets it. It also derives the active horizontal resolution from the mode bits of the status word.

Information queries return one of eight environment shadow words, which the command framer supplies as an input. The decoder masks the chosen word and holds it in a read-back register. Every register updates on the clock edge that samples the write strobe, so a new value is visible in the cycle after the write.

Top module: `dispctl_decoder`

## Requirements
- R1: While reset is high and after it is released, the status word is 1480_2000h. The display start, horizontal range, vertical range and read-back value are all zero, and the reported width is 256.
- R2: Command 03h sets status bit 23, the blanking flag, to data bit 0. No other bit of the status word changes.
- R3: Command 04h copies data bits 1:0 into status bits 30:29, the DMA-direction field. The rest of the status word is kept.
- R4: Command 05h loads the display start X from data bits 9:0 and the display start Y from data bits 18:10.
- R5: Command 06h loads the horizontal range start from data bits 11:0 and the horizontal range end from data bits 23:12.
- R6: Command 07h loads the vertical range start from data bits 9:0 and the vertical range end from data bits 19:10.
- R7: Command 08h writes data bits 5:0 into status bits 22:17 and data bit 6 into status bit 16. The other status bits are kept.
- R8: Commands 10h to 1Fh are queries. Each one loads the read-back value with shadow word data[2:0], taken from bits [32*i+31:32*i] of the shadow input, as sampled at the write edge. The word is masked to its low 20 bits, except index 5, which is masked to its low 22 bits. A query leaves the status word and the geometry unchanged.
- R9: The reported width follows status bits 18:16. The values 0 to 7 map to 256, 368, 320, 368, 512, 368, 640 and 368 pixels.
- R10: A write with any other command number changes no output. A cycle without the write strobe also changes no output. Only a query changes the read-back value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control-port write strobe |
| wr_data | input | 32 | Command (31:24) and argument |
| shadow_flat | input | 256 | Eight environment shadow words, word i at bits 32*i+31:32*i |
| status_word | output | 32 | Status register |
| disp_x | output | 10 | Display start X |
| disp_y | output | 9 | Display start Y |
| hrange_lo | output | 12 | Horizontal range start |
| hrange_hi | output | 12 | Horizontal range end |
| vrange_lo | output | 10 | Vertical range start |
| vrange_hi | output | 10 | Vertical range end |
| hmode_width | output | 10 | Horizontal resolution in pixels |
| query_data | output | 32 | Masked read-back of the last query |

## Verification
Two pairs of effects can land on the same edge. First, a display-mode write updates the status bits and the derived width together, so the bench sweeps all 128 mode arguments and checks both values in the cycle that follows. Second, a query samples the shadow input on the very edge where the framer may already be changing it. The bench changes every shadow word just after the query edge and expects the read-back to hold the pre-edge word, masked as R8 requires.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

    localparam int WORD_W        = 32;
    localparam int CMD_W         = 8;
    localparam int NUM_SHADOW    = 8;
    localparam int SHADOW_IDX_W  = $clog2(NUM_SHADOW);
    localparam int START_X_W     = 10;
    localparam int START_Y_W     = 9;
    localparam int HPOS_W        = 12;
    localparam int VPOS_W        = 10;
    localparam int WIDTH_W       = 10;

    localparam logic [WORD_W-1:0] STATUS_RESET = 32'h1480_2000;
    localparam int BLANK_BIT     = 23;
    localparam int DMA_LSB       = 29;
    localparam int DMA_W         = 2;
    localparam int MODE_LSB      = 16;
    localparam int MODE_W        = 7;
    localparam int HSEL_W        = 3;

    localparam int QMASK_NARROW  = 20;
    localparam int QMASK_WIDE    = 22;
    localparam int QWIDE_IDX     = 5;

    typedef enum logic [2:0] {
        OP_NONE, OP_BLANK, OP_DMADIR, OP_START,
        OP_HSPAN, OP_VSPAN, OP_MODE, OP_QUERY
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [WORD_W-1:0] arg;
    } cmd_t;

    typedef struct packed {
        logic [START_X_W-1:0] start_x;
        logic [START_Y_W-1:0] start_y;
        logic [HPOS_W-1:0]    h_lo;
        logic [HPOS_W-1:0]    h_hi;
        logic [VPOS_W-1:0]    v_lo;
        logic [VPOS_W-1:0]    v_hi;
    } geom_t;

    function automatic op_e classify(input logic [CMD_W-1:0] c);
        op_e r;
        case (c)
            8'h03:   r = OP_BLANK;
            8'h04:   r = OP_DMADIR;
            8'h05:   r = OP_START;
            8'h06:   r = OP_HSPAN;
            8'h07:   r = OP_VSPAN;
            8'h08:   r = OP_MODE;
            default: r = (c[7:4] == 4'h1) ? OP_QUERY : OP_NONE;
        endcase
        return r;
    endfunction

    function automatic logic [WIDTH_W-1:0] mode_width(input logic [HSEL_W-1:0] m);
        logic [WIDTH_W-1:0] w;
        if (m[0]) begin
            w = 10'd368;
        end else begin
            case (m[2:1])
                2'd0:    w = 10'd256;
                2'd1:    w = 10'd320;
                2'd2:    w = 10'd512;
                default: w = 10'd640;
            endcase
        end
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] query_mask(input int idx);
        int bits;
        bits = (idx == QWIDE_IDX) ? QMASK_WIDE : QMASK_NARROW;
        return (WORD_W'(1) << bits) - WORD_W'(1);
    endfunction

endpackage

// File: rtl/dispctl_cmd_decode.sv
module dispctl_cmd_decode
    import dispctl_pkg::*;
(
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output cmd_t              cmd
);
    always_comb begin
        cmd.arg = wr_data;
        cmd.op  = wr_en ? classify(wr_data[WORD_W-1 -: CMD_W]) : OP_NONE;
    end
endmodule

// File: rtl/dispctl_status_reg.sv
module dispctl_status_reg
    import dispctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  cmd_t               cmd,
    output logic [WORD_W-1:0]  status,
    output logic [WIDTH_W-1:0] width
);
    logic unused_arg;
    assign unused_arg = ^cmd.arg[WORD_W-1:MODE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= STATUS_RESET;
        end else begin
            case (cmd.op)
                OP_BLANK:  status[BLANK_BIT] <= cmd.arg[0];
                OP_DMADIR: status[DMA_LSB +: DMA_W] <= cmd.arg[DMA_W-1:0];
                OP_MODE:   status[MODE_LSB +: MODE_W] <= {cmd.arg[MODE_W-2:0], cmd.arg[MODE_W-1]};
                default:   ;
            endcase
        end
    end

    assign width = mode_width(status[MODE_LSB +: HSEL_W]);
endmodule

// File: rtl/dispctl_geom_regs.sv
module dispctl_geom_regs
    import dispctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cmd_t  cmd,
    output geom_t geom
);
    localparam int USED_W = 2 * HPOS_W;

    logic unused_arg;
    assign unused_arg = ^cmd.arg[WORD_W-1:USED_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            geom <= '0;
        end else begin
            case (cmd.op)
                OP_START: begin
                    geom.start_x <= cmd.arg[START_X_W-1:0];
                    geom.start_y <= cmd.arg[START_X_W +: START_Y_W];
                end
                OP_HSPAN: begin
                    geom.h_lo <= cmd.arg[HPOS_W-1:0];
                    geom.h_hi <= cmd.arg[HPOS_W +: HPOS_W];
                end
                OP_VSPAN: begin
                    geom.v_lo <= cmd.arg[VPOS_W-1:0];
                    geom.v_hi <= cmd.arg[VPOS_W +: VPOS_W];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dispctl_query_port.sv
module dispctl_query_port
    import dispctl_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  cmd_t                         cmd,
    input  logic [NUM_SHADOW*WORD_W-1:0] shadow_flat,
    output logic [WORD_W-1:0]            rdata
);
    logic [WORD_W-1:0] masked [NUM_SHADOW];

    for (genvar i = 0; i < NUM_SHADOW; i++) begin : g_mask
        assign masked[i] = shadow_flat[i*WORD_W +: WORD_W] & query_mask(i);
    end

    logic unused_arg;
    assign unused_arg = ^cmd.arg[WORD_W-1:SHADOW_IDX_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (cmd.op == OP_QUERY) begin
            rdata <= masked[cmd.arg[SHADOW_IDX_W-1:0]];
        end
    end
endmodule

// File: rtl/dispctl_decoder.sv
module dispctl_decoder
    import dispctl_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [WORD_W-1:0]            wr_data,
    input  logic [NUM_SHADOW*WORD_W-1:0] shadow_flat,
    output logic [WORD_W-1:0]            status_word,
    output logic [START_X_W-1:0]         disp_x,
    output logic [START_Y_W-1:0]         disp_y,
    output logic [HPOS_W-1:0]            hrange_lo,
    output logic [HPOS_W-1:0]            hrange_hi,
    output logic [VPOS_W-1:0]            vrange_lo,
    output logic [VPOS_W-1:0]            vrange_hi,
    output logic [WIDTH_W-1:0]           hmode_width,
    output logic [WORD_W-1:0]            query_data
);
    cmd_t  cmd;
    geom_t geom;

    dispctl_cmd_decode u_decode (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    dispctl_status_reg u_status (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .status (status_word),
        .width  (hmode_width)
    );

    dispctl_geom_regs u_geom (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .geom (geom)
    );

    dispctl_query_port u_query (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .shadow_flat (shadow_flat),
        .rdata       (query_data)
    );

    assign disp_x    = geom.start_x;
    assign disp_y    = geom.start_y;
    assign hrange_lo = geom.h_lo;
    assign hrange_hi = geom.h_hi;
    assign vrange_lo = geom.v_lo;
    assign vrange_hi = geom.v_hi;
endmodule

// File: rtl/dispctl_checker.sv
module dispctl_checker (
    input logic         clk,
    input logic         rst,
    input logic         wr_en,
    input logic [31:0]  wr_data,
    input logic [255:0] shadow_flat,
    input logic [31:0]  status_word,
    input logic [9:0]   disp_x,
    input logic [8:0]   disp_y,
    input logic [11:0]  hrange_lo,
    input logic [11:0]  hrange_hi,
    input logic [9:0]   vrange_lo,
    input logic [9:0]   vrange_hi,
    input logic [9:0]   hmode_width,
    input logic [31:0]  query_data
);
    logic [7:0]  c;
    logic        known;
    logic        is_query;
    logic [31:0] pick;
    logic [31:0] pick_mask;

    assign c         = wr_data[31:24];
    assign is_query  = (c[7:4] == 4'h1);
    assign known     = is_query || (c >= 8'h03 && c <= 8'h08);
    assign pick      = shadow_flat[wr_data[2:0]*32 +: 32];
    assign pick_mask = (wr_data[2:0] == 3'd5) ? 32'h003F_FFFF : 32'h000F_FFFF;

    p_reset_status_r1: assert property (@(posedge clk)
        rst |=> status_word == 32'h1480_2000);

    p_blank_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && c == 8'h03) |=> status_word[23] == $past(wr_data[0])
            && status_word[22:0] == $past(status_word[22:0]));

    p_dma_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && c == 8'h04) |=> status_word[30:29] == $past(wr_data[1:0])
            && status_word[28:0] == $past(status_word[28:0]));

    p_start_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && c == 8'h05) |=> disp_x == $past(wr_data[9:0])
            && disp_y == $past(wr_data[18:10]));

    p_hspan_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && c == 8'h06) |=> hrange_lo == $past(wr_data[11:0])
            && hrange_hi == $past(wr_data[23:12]));

    p_vspan_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && c == 8'h07) |=> vrange_lo == $past(wr_data[9:0])
            && vrange_hi == $past(wr_data[19:10]));

    p_mode_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && c == 8'h08) |=> status_word[22:17] == $past(wr_data[5:0])
            && status_word[16] == $past(wr_data[6]));

    p_query_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_query) |=> query_data == $past(pick & pick_mask)
            && $stable(status_word) && $stable(disp_x) && $stable(hrange_hi));

    p_width_odd_r9: assert property (@(posedge clk) disable iff (rst)
        status_word[16] |-> hmode_width == 10'd368);

    p_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || !known) |=> $stable(status_word) && $stable(query_data)
            && $stable(disp_x) && $stable(disp_y) && $stable(hrange_lo)
            && $stable(hrange_hi) && $stable(vrange_lo) && $stable(vrange_hi));
endmodule

bind dispctl_decoder dispctl_checker u_chk (.*);

// File: tb/dispctl_decoder_bench.sv
module dispctl_decoder_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [31:0]  wr_data = '0;
    logic [255:0] shadow_flat = '0;
    logic [31:0]  status_word, query_data;
    logic [9:0]   disp_x, vrange_lo, vrange_hi, hmode_width;
    logic [8:0]   disp_y;
    logic [11:0]  hrange_lo, hrange_hi;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [31:0] e_status, e_query;
    logic [9:0]  e_x, e_vlo, e_vhi;
    logic [8:0]  e_y;
    logic [11:0] e_hlo, e_hhi;

    always #(CLK_PERIOD/2) clk = ~clk;

    dispctl_decoder u_dispctl_decoder (.*);

    function automatic logic [9:0] exp_width(input logic [2:0] m);
        case (m)
            3'd0: return 10'd256;
            3'd2: return 10'd320;
            3'd4: return 10'd512;
            3'd6: return 10'd640;
            default: return 10'd368;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(status_word == e_status, {tag, " status"}, status_word, e_status);
        check(disp_x == e_x && disp_y == e_y, {tag, " start"},
              {13'd0, disp_y, disp_x}, {13'd0, e_y, e_x});
        check(hrange_lo == e_hlo && hrange_hi == e_hhi, {tag, " hspan"},
              {8'd0, hrange_hi, hrange_lo}, {8'd0, e_hhi, e_hlo});
        check(vrange_lo == e_vlo && vrange_hi == e_vhi, {tag, " vspan"},
              {12'd0, vrange_hi, vrange_lo}, {12'd0, e_vhi, e_vlo});
        check(query_data == e_query, {tag, " query"}, query_data, e_query);
        check(hmode_width == exp_width(e_status[18:16]), {tag, " width R9"},
              {22'd0, hmode_width}, {22'd0, exp_width(e_status[18:16])});
    endtask

    task automatic model(input logic [31:0] d);
        logic [31:0] w;
        case (d[31:24])
            8'h03: e_status[23] = d[0];
            8'h04: e_status[30:29] = d[1:0];
            8'h05: begin e_x = d[9:0];   e_y = d[18:10];   end
            8'h06: begin e_hlo = d[11:0]; e_hhi = d[23:12]; end
            8'h07: begin e_vlo = d[9:0];  e_vhi = d[19:10]; end
            8'h08: begin e_status[22:17] = d[5:0]; e_status[16] = d[6]; end
            default: if (d[31:28] == 4'h1) begin
                w = shadow_flat[d[2:0]*32 +: 32];
                e_query = (d[2:0] == 3'd5) ? (w & 32'h003F_FFFF) : (w & 32'h000F_FFFF);
            end
        endcase
    endtask

    task automatic write(input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        model(d);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic fill_shadow(input int seed);
        for (int i = 0; i < 8; i++)
            shadow_flat[i*32 +: 32] = (32'h9E37_79B9 * (seed + 1)) ^ (32'h0101_0101 * (i + 3)) ^ 32'hFFF0_0000;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        e_status = 32'h1480_2000;
        e_query = '0; e_x = '0; e_y = '0;
        e_hlo = '0; e_hhi = '0; e_vlo = '0; e_vhi = '0;
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 during reset");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check_all("R1 after reset");

        // R2: blanking flag follows data bit 0 only
        write(32'h0300_0000); check_all("R2 clear");
        write(32'h03FF_FFFF); check_all("R2 set");
        write(32'h03FF_FFFE); check_all("R2 clear junk");

        // R3: DMA-direction field
        for (int v = 0; v < 4; v++) begin
            write(32'h0400_0000 | 32'h00AB_CDE0 | v);
            check_all("R3 dma");
        end

        // R4, R5, R6 with several patterns
        write(32'h05FF_FFFF); check_all("R4 ones");
        write(32'h0500_0000 | (9'h155 << 10) | 10'h2AA); check_all("R4 alt");
        write(32'h0600_0000 | (12'hABC << 12) | 12'h123); check_all("R5 alt");
        write(32'h06FF_FFFF); check_all("R5 ones");
        write(32'h07FF_FFFF); check_all("R6 ones");
        write(32'h0700_0000 | (10'h201 << 10) | 10'h3FE); check_all("R6 alt");

        // R7, R9: exhaustive mode sweep
        for (int m = 0; m < 128; m++) begin
            write(32'h0800_0000 | ((m * 32'h1357) << 7) & 32'h00FF_FF80 | m);
            check_all("R7 mode");
        end

        // R8: every query command and index over two shadow patterns
        for (int s = 0; s < 2; s++) begin
            fill_shadow(s);
            for (int q = 16; q < 32; q++)
                for (int i = 0; i < 8; i++) begin
                    write((q << 24) | ((q * 7 + s) << 3) & 32'h00FF_FFF8 | i);
                    check_all("R8 query");
                end
        end

        // R8: shadow changes right after the query edge
        fill_shadow(5);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h1A00_0005; model(32'h1A00_0005);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        fill_shadow(9);
        check_all("R8 same-edge shadow change");

        // R10: unrecognized commands and idle strobe
        for (int c = 0; c < 256; c++) begin
            if (!((c >= 3 && c <= 8) || (c >= 16 && c <= 31))) begin
                write((c << 24) | 32'h00FF_FFFF);
                check_all("R10 unknown");
            end
        end
        @(negedge clk);
        wr_en = 1'b0; wr_data = 32'h0800_007F;
        @(posedge clk); #1;
        check_all("R10 no strobe mode");
        @(negedge clk);
        wr_data = 32'h1000_0005;
        @(posedge clk); #1;
        check_all("R10 no strobe query");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule